// File: doc/BRIEF.md
# Serial Word EEPROM Slave Controller

This block is the device side of a serial nonvolatile memory of 512 sixteen-bit words, with the storage modelled by a register array. A host selects it by pulling an active-low select line, clocks a frame in on a serial data pin, and receives read data on a serial output that is tristated (value plus enable) whenever the block is not talking. A ready line reports whether a self-timed program cycle is running. All serial inputs are brought into the system clock through a synchronizer, and the serial clock edges are found there.

A frame opens with a four-bit start pattern, then three command bits, then nine address bits sent least significant bit first. Two command frames set or clear a write permission latch. A read frame streams words out, moving to the next address every sixteen serial clocks for as long as the serial clock runs. A write frame carries sixteen data bits after the address and then starts a program period timed in system clock cycles. A write-lock input can refuse or abandon programming. While a program period runs, a newly selected session whose select falls with the serial clock low shows the ready state on the data output.

Top module: `eep_serial_slave`

## Requirements
- R1: A frame counts only if its first four bits received are 1,0,1,0; any other start pattern leaves the array, the write permission and the data output (enable held 0) untouched for the rest of that session.
- R2: After reset, ready is 1, the output enable is 0 and writing is not permitted: a write frame sent before any enable command does not start a program period.
- R3: Bits 5 to 8 equal to 0,0,1,1 permit writing and 0,0,0,0 forbid it; the write-lock input has no effect on either command, and a write frame sent while forbidden leaves the addressed word unchanged.
- R4: A read frame has bits 5 to 7 equal to 1,0,0 and the address A0 to A8 in bits 8 to 16; the output enable stays 0 until the falling serial clock edge that ends bit 16, where D0 appears, and D1 to D15 follow on the next falling edges.
- R5: A read continues with the word at the next address on every further 16 falling edges, and the address wraps from 511 to 0.
- R6: Raising the select line ends any session in progress and the output enable returns to 0.
- R7: A write frame has bits 5 to 7 equal to 0,1,0, the address in bits 8 to 16 and D0 to D15 in bits 17 to 32; when permitted and with write-lock low at bit 32, ready drops after that rising edge for PROG_CYCLES system clock cycles and the word is stored when it rises again.
- R8: The select line may be released during a program period, and no frame started during that period has any effect.
- R9: Write-lock high at the 32nd rising edge prevents the program period; write-lock going high during the period ends it within a few cycles and leaves the word unchanged.
- R10: Write-lock has no effect on read frames.
- R11: When the select line falls while the serial clock is low during a program period, the data output is enabled and shows the ready state until the select line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in, sampled on rising serial clock |
| wr_lock | input | 1 | Write-lock, high refuses or abandons programming |
| sdout | output | 1 | Serial data out value |
| sdout_en | output | 1 | Serial data out enable (0 means high impedance) |
| rdy | output | 1 | 1 when no program period is running |

## Verification
Stimulus mixes directed frames with random address and data write/readback pairs drawn from a fixed seed. Directed patterns cover a burst read crossing the top address, which separates a correct wrap from a stuck or overflowing address; writes with permission off, on, and write-lock high, which tell a refused frame from an accepted one through readback; a corrupted start pattern; a read cut short by the select line; and a program period abandoned by write-lock, plus sessions opened while busy, which separate status display from command decoding.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_WDATA,
        ST_RDOUT,
        ST_STAT,
        ST_SKIP
    } sess_e;

    // first four frame bits, stored LSB = first bit
    localparam logic [3:0] START_PAT = 4'b0101;
    localparam logic [2:0] OP_READ   = 3'b001;
    localparam logic [2:0] OP_WRITE  = 3'b010;
    localparam logic [3:0] OPX_WEN   = 4'b1100;
    localparam logic [3:0] OPX_WDIS  = 4'b0000;
endpackage

// File: rtl/eep_insync.sv
module eep_insync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [STAGES:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {(STAGES+1){RST_VAL}};
        else        stg_q <= {stg_q[STAGES-1:0], d};
    end

    assign q      = stg_q[STAGES-1];
    assign q_prev = stg_q[STAGES];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    logic          busy_q, busy_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        done   = 1'b0;
        if (busy_q) begin
            if (abort) begin
                busy_d = 1'b0;
            end else if (cnt_q == '0) begin
                busy_d = 1'b0;
                done   = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end else if (start) begin
            busy_d = 1'b1;
            cnt_d  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end

    assign busy = busy_q;

    AST_TMR_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && abort) |=> !busy_q);  // R9
    AST_TMR_ABORT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && abort) |-> !done);  // R9
    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);  // R8
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

    AST_ARR_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr));  // R7
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sclk,
    input  logic sdin,
    input  logic wr_lock,
    output logic sdout,
    output logic sdout_en,
    output logic rdy
);
    localparam int HDR_BITS   = 7 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int OCNT_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0]  FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [OCNT_W-1:0] WORD_LAST  = OCNT_W'(DATA_W - 1);

    typedef struct packed {
        sess_e               st;
        logic [CNT_W-1:0]    cnt;
        logic [HDR_BITS-1:0] sr;
        logic [DATA_W-1:0]   dat;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   osr;
        logic [OCNT_W-1:0]   ocnt;
        logic                wen;
        logic                dout;
        logic                oe;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0] sy, sy_prev;
    logic sel_s, sel_prev, sk_s, sk_prev, di_s, wc_s;
    logic sel_rise, sel_fall, sk_rise, sk_fall;
    logic t_start, t_busy, t_done;
    logic [DATA_W-1:0] rdata;

    eep_insync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({wr_lock, sdin, sclk, sel_n}),
        .q(sy), .q_prev(sy_prev)
    );

    assign sel_s    = sy[0];
    assign sel_prev = sy_prev[0];
    assign sk_s     = sy[1];
    assign sk_prev  = sy_prev[1];
    assign di_s     = sy[2];
    assign wc_s     = sy[3];
    assign sel_rise = sel_s & ~sel_prev;
    assign sel_fall = ~sel_s & sel_prev;
    assign sk_rise  = sk_s & ~sk_prev;
    assign sk_fall  = ~sk_s & sk_prev;

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .start(t_start), .abort(wc_s),
        .busy(t_busy), .done(t_done)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n),
        .we(t_done), .waddr(r_q.wr_addr), .wdata(r_q.wr_data),
        .raddr(r_q.addr), .rdata(rdata)
    );

    always_comb begin
        r_d     = r_q;
        t_start = 1'b0;
        if (sel_rise) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (sel_fall) begin
            r_d.cnt = '0;
            if (t_busy) begin
                r_d.st   = sk_s ? ST_SKIP : ST_STAT;
                r_d.oe   = ~sk_s;
                r_d.dout = ~t_busy;
            end else begin
                r_d.st = ST_RECV;
            end
        end else begin
            unique case (r_q.st)
                ST_RECV: if (sk_rise) begin
                    r_d.sr  = {di_s, r_q.sr[HDR_BITS-1:1]};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == HDR_LAST) begin
                        r_d.addr = r_d.sr[HDR_BITS-1:7];
                        r_d.st   = ST_SKIP;
                        if (r_d.sr[3:0] == START_PAT) begin
                            if (r_d.sr[6:4] == OP_READ) begin
                                r_d.st   = ST_RDOUT;
                                r_d.ocnt = '0;
                            end else if (r_d.sr[6:4] == OP_WRITE) begin
                                r_d.st = ST_WDATA;
                            end else if (r_d.sr[7:4] == OPX_WEN) begin
                                r_d.wen = 1'b1;
                            end else if (r_d.sr[7:4] == OPX_WDIS) begin
                                r_d.wen = 1'b0;
                            end
                        end
                    end
                end
                ST_WDATA: if (sk_rise) begin
                    r_d.dat = {di_s, r_q.dat[DATA_W-1:1]};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == FRAME_LAST) begin
                        r_d.st = ST_SKIP;
                        if (r_q.wen && !wc_s) begin
                            t_start     = 1'b1;
                            r_d.wr_addr = r_q.addr;
                            r_d.wr_data = r_d.dat;
                        end
                    end
                end
                ST_RDOUT: if (sk_fall) begin
                    r_d.oe = 1'b1;
                    if (r_q.ocnt == '0) begin
                        r_d.dout = rdata[0];
                        r_d.osr  = rdata >> 1;
                    end else begin
                        r_d.dout = r_q.osr[0];
                        r_d.osr  = r_q.osr >> 1;
                    end
                    r_d.ocnt = r_q.ocnt + 1'b1;
                    if (r_q.ocnt == WORD_LAST) r_d.addr = r_q.addr + 1'b1;
                end
                ST_STAT: r_d.dout = ~t_busy;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sdout    = r_q.dout;
    assign sdout_en = r_q.oe;
    assign rdy      = ~t_busy;

    AST_STORE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |-> r_q.wen);  // R3
    AST_DESELECT_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && sel_prev) |-> !sdout_en);  // R6
    AST_STATUS_TRACKS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STAT && $past(r_q.st == ST_STAT)) |-> (sdout_en && sdout == $past(rdy)));  // R11
endmodule

// File: tb/test_eep_serial_slave.sv
module test_eep_serial_slave;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic wr_lock = 1'b0;
    logic sdout, sdout_en, rdy;

    int nchk = 0;
    int nfail = 0;
    bit fin = 1'b0;
    logic [15:0] model [512];

    always #2 clk = ~clk;

    eep_serial_slave #(.PROG_CYCLES(PROG)) i_eep_serial_slave (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .wr_lock(wr_lock), .sdout(sdout), .sdout_en(sdout_en), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sk_cycle(input logic d, output logic dv, output logic ev);
        sdin = d;
        repeat (4) @(posedge clk);
        sclk = 1'b1;
        repeat (8) @(posedge clk);
        sclk = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        dv = sdout;
        ev = sdout_en;
    endtask

    task automatic cs_low();
        @(negedge clk) sel_n = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk) sel_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    // frame bits in send order: start 1,0,1,0 then op[0..2] then A0..A8
    task automatic send_hdr(input logic [3:0] st, input logic [2:0] op, input logic [8:0] a,
                            output logic oe15, output logic d16, output logic oe16);
        logic [15:0] h;
        logic dv, ev;
        h = {a, op, st};
        oe15 = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sk_cycle(h[i], dv, ev);
            if (i == 14) oe15 = ev;
        end
        d16 = dv;
        oe16 = ev;
    endtask

    task automatic do_read(input logic [8:0] a, input int n, input string req);
        logic oe15, d16, oe16, dv, ev;
        logic [15:0] cur;
        logic [8:0] wa;
        cs_low();
        send_hdr(4'b0101, 3'b001, a, oe15, d16, oe16);
        chk("R4 enable before D0", {31'b0, oe15}, 32'd0);
        chk("R4 enable at D0", {31'b0, oe16}, 32'd1);
        cur = '0;
        cur[0] = d16;
        for (int k = 1; k < 16 * n; k++) begin
            sk_cycle(1'b0, dv, ev);
            cur[k % 16] = dv;
            if (k % 16 == 15) begin
                wa = a + 9'(k / 16);
                chk(req, {16'b0, cur}, {16'b0, model[wa]});
            end
        end
        cs_high();
    endtask

    task automatic do_write(input logic [8:0] a, input logic [15:0] d, output logic started);
        logic oe15, d16, oe16, dv, ev;
        cs_low();
        send_hdr(4'b0101, 3'b010, a, oe15, d16, oe16);
        for (int i = 0; i < 16; i++) sk_cycle(d[i], dv, ev);
        started = ~rdy;
        cs_high();
    endtask

    task automatic do_cmd(input logic en);
        logic oe15, d16, oe16;
        cs_low();
        send_hdr(4'b0101, en ? 3'b100 : 3'b000, en ? 9'h1FF : 9'h000, oe15, d16, oe16);
        cs_high();
    endtask

    task automatic wait_rdy(output int cyc);
        cyc = 0;
        while (!rdy && cyc < 3000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    task automatic wr_ok(input logic [8:0] a, input logic [15:0] d, input string req);
        logic st;
        int cyc;
        do_write(a, d, st);
        chk(req, {31'b0, st}, 32'd1);
        wait_rdy(cyc);
        model[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic st, dv, ev, oe15, d16, oe16;
        int cyc;
        logic [8:0] ra;
        logic [15:0] rd;
        void'($urandom(32'd4242));

        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R2 rdy after reset", {31'b0, rdy}, 32'd1);
        chk("R2 enable after reset", {31'b0, sdout_en}, 32'd0);

        // R2: write refused before any enable
        do_write(9'd5, 16'hBEEF, st);
        chk("R2 write before enable", {31'b0, st}, 32'd0);

        // R3: enable with write-lock high still permits
        wr_lock = 1'b1;
        do_cmd(1'b1);
        wr_lock = 1'b0;
        do_write(9'd5, 16'h1234, st);
        chk("R3 write after enable", {31'b0, st}, 32'd1);
        wait_rdy(cyc);
        chk("R7 program period length", {31'b0, (cyc > PROG - 60 && cyc <= PROG)}, 32'd1);
        model[5] = 16'h1234;
        do_read(9'd5, 1, "R7 stored word");

        // R3: disable with write-lock high still forbids
        wr_lock = 1'b1;
        do_cmd(1'b0);
        wr_lock = 1'b0;
        do_write(9'd5, 16'hFFFF, st);
        chk("R3 write after disable", {31'b0, st}, 32'd0);
        do_read(9'd5, 1, "R3 word unchanged");

        do_cmd(1'b1);
        wr_ok(9'd510, 16'hA510, "R7 start 510");
        wr_ok(9'd511, 16'h5A11, "R7 start 511");
        wr_ok(9'd0,   16'h0F00, "R7 start 0");
        wr_ok(9'd1,   16'hC001, "R7 start 1");
        wr_ok(9'd7,   16'h7777, "R7 start 7");
        wr_ok(9'd8,   16'h8001, "R7 start 8");
        wr_ok(9'd22,  16'h2222, "R7 start 22");

        do_read(9'd510, 4, "R5 burst wrap");
        wr_lock = 1'b1;
        do_read(9'd7, 2, "R10 read with write-lock high");
        wr_lock = 1'b0;

        // R6: read cut short by select
        cs_low();
        send_hdr(4'b0101, 3'b001, 9'd5, oe15, d16, oe16);
        chk("R6 read running", {31'b0, oe16}, 32'd1);
        for (int i = 0; i < 3; i++) sk_cycle(1'b0, dv, ev);
        cs_high();
        chk("R6 enable after deselect", {31'b0, sdout_en}, 32'd0);
        do_read(9'd5, 1, "R6 fresh read after abort");

        // R1: corrupted start pattern, write command body
        cs_low();
        send_hdr(4'b0111, 3'b010, 9'd5, oe15, d16, oe16);
        for (int i = 0; i < 16; i++) sk_cycle(1'b0, dv, ev);
        chk("R1 bad start no program", {31'b0, rdy}, 32'd1);
        chk("R1 bad start no output", {31'b0, ev}, 32'd0);
        cs_high();
        do_read(9'd5, 1, "R1 word unchanged");

        // R9: write-lock at the final edge
        wr_lock = 1'b1;
        do_write(9'd7, 16'h0000, st);
        wr_lock = 1'b0;
        chk("R9 lock at last edge", {31'b0, st}, 32'd0);
        // R9: write-lock during the program period
        do_write(9'd7, 16'h1111, st);
        chk("R9 program started", {31'b0, st}, 32'd1);
        repeat (40) @(posedge clk);
        wr_lock = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R9 abort frees rdy", {31'b0, rdy}, 32'd1);
        wr_lock = 1'b0;
        do_read(9'd7, 1, "R9 word unchanged after abort");

        // R11: status display
        do_write(9'd20, 16'h2020, st);
        chk("R11 program started", {31'b0, st}, 32'd1);
        model[20] = 16'h2020;
        cs_low();
        chk("R11 status enabled", {31'b0, sdout_en}, 32'd1);
        chk("R11 status busy", {31'b0, sdout}, 32'd0);
        wait_rdy(cyc);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R11 status ready", {30'b0, sdout_en, sdout}, 32'd3);
        cs_high();
        chk("R11 released", {31'b0, sdout_en}, 32'd0);

        // R8: frame during a program period is ignored
        do_write(9'd21, 16'h2121, st);
        chk("R8 first write", {31'b0, st}, 32'd1);
        model[21] = 16'h2121;
        do_write(9'd22, 16'hDEAD, st);
        wait_rdy(cyc);
        chk("R8 no second program", {31'b0, rdy}, 32'd1);
        do_read(9'd22, 1, "R8 word unchanged");
        do_read(9'd21, 1, "R8 first word stored");

        // random write/readback pairs
        for (int n = 0; n < 6; n++) begin
            ra = 9'($urandom % 512);
            rd = 16'($urandom);
            wr_ok(ra, rd, "R7 random start");
            do_read(ra, 1, "R4 random readback");
        end

        fin = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule